// File: doc/BRIEF.md
# Multichannel DAC Serial Command Core

This block is the digital front end of a converter with up to eight output channels. It takes 32-bit command words from a serial peripheral interface and decodes them. The interface has a serial clock, an active-low frame select and a data input, and words arrive most significant bit first. Each channel holds a staging register and an active register. Sample codes are written into the staging register first and are later moved to the active register by a command, by a load strobe, or in the same command as the write. The core also holds a per-channel output-off mode, a per-channel mask for the load strobe, a selectable clear target driven by a clear pin, a command reset, and two configuration flags.

The serial pins are sampled in the system clock domain. A word is executed only when the frame select rises after exactly 32 falling serial clock edges. Resolution (`RES`) and channel count (`NCH`) are parameters. The outputs are the active code of every channel, a 2-bit output-off mode per channel, and the configuration flags.

Top module: `mdac_cmd_core`

## Requirements
- R1: A word is taken MSB first, one bit per falling `sclk` edge while `csn` is low. It is executed when `csn` rises after exactly 32 such edges. The opcode is in bits 27:24, the address in bits 23:20 and the payload in bits 19:0.
- R2: A frame with any edge count other than 32 (for example 31 or 33) changes no state and no output.
- R3: The sample code is left-aligned in the payload as bits 19 down to 20-RES. Payload bits below it are ignored for sample writes.
- R4: Opcode 0 writes the staging register of the addressed channel and leaves the active code unchanged. Opcode 1 copies the addressed staging register into its active register.
- R5: Opcode 3 writes both the staging and active register of the addressed channel. Opcode 2 writes the addressed staging register and then loads every active register from its staging register.
- R6: Address 15 selects every channel. Channel i answers to address i, except in a two-channel build, where channel 1 answers to address 3 and address 1 selects nothing.
- R7: Opcode 4 sets the output-off mode of each channel whose payload bit at the channel's address index is 1, using payload bits 9:8 as the mode (0 on, 1 1 kOhm to ground, 2 100 kOhm to ground, 3 floating). Other channels keep their mode.
- R8: Opcode 6 loads the strobe mask from the payload bit at each channel's address index. In every clock cycle with `ldac` high, each channel whose mask bit is 0 copies its staging register to its active register.
- R9: Opcode 5 selects the clear target from payload bits 1:0 (0 zero, 1 midscale, 2 full scale, 3 disabled). While `clr` is high and the target is not disabled, every active register is forced to the target. Staging registers are not affected.
- R10: Opcode 7 returns the staging, active, output-off, mask and configuration state to the reset values, with no further frame needed. The clear target is kept.
- R11: Opcode 8 sets `int_ref_en` from payload bit 0 and `daisy_en` from payload bit 1.
- R12: After `rst`, every staging and active register holds midscale, 2^(RES-1). Modes are 0, masks are 0, flags are 0 and the clear target is disabled.
- R13: Opcodes 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, data taken on falling edges |
| csn | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data, MSB first |
| ldac | input | 1 | Load strobe, active high |
| clr | input | 1 | Clear pin, active high |
| dac_code | output | NCH*RES | Active codes, channel i at bits i*RES +: RES |
| pd_mode | output | 2*NCH | Output-off mode, channel i at bits 2*i +: 2 |
| int_ref_en | output | 1 | Internal reference enable flag |
| daisy_en | output | 1 | Daisy-chain enable flag |

## Verification
Staging registers have no output. A wrong staging value therefore shows up only when a later load, whether opcode 1, opcode 2 or the strobe, moves it to `dac_code`. The bench follows each write with such a load within a few frames. A miscounted frame or a bad field split shows up at the ports within three clock cycles of `csn` rising: the wrong channel or wrong bits change, or a discarded frame takes effect. Mask, mode and clear-target errors are seen on the first strobe, power-down word or clear pulse after the error.

// File: rtl/mdac_pkg.sv
package mdac_pkg;

    localparam int unsigned FRAME_BITS = 32;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 2);

    localparam logic [3:0] OP_WR_IN       = 4'd0;
    localparam logic [3:0] OP_LOAD        = 4'd1;
    localparam logic [3:0] OP_WR_LOAD_ALL = 4'd2;
    localparam logic [3:0] OP_WR_LOAD     = 4'd3;
    localparam logic [3:0] OP_PWR         = 4'd4;
    localparam logic [3:0] OP_CLR_SEL     = 4'd5;
    localparam logic [3:0] OP_STB_MASK    = 4'd6;
    localparam logic [3:0] OP_SOFT_RST    = 4'd7;
    localparam logic [3:0] OP_CONFIG      = 4'd8;

    localparam logic [3:0] ADDR_ALL = 4'hF;

    localparam logic [1:0] TGT_ZERO = 2'd0;
    localparam logic [1:0] TGT_MID  = 2'd1;
    localparam logic [1:0] TGT_FULL = 2'd2;
    localparam logic [1:0] TGT_NONE = 2'd3;

    typedef struct packed {
        logic [3:0]  pad;
        logic [3:0]  op;
        logic [3:0]  addr;
        logic [19:0] data;
    } frame_t;

    // address a channel answers to; two-channel builds use 0 and 3
    function automatic int unsigned chan_addr(input int unsigned idx, input int unsigned nch);
        return (nch == 2 && idx == 1) ? 3 : idx;
    endfunction

endpackage

// File: rtl/mdac_spi_rx.sv
module mdac_spi_rx import mdac_pkg::*; (
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk,
    input  logic   csn,
    input  logic   sdi,
    output logic   frm_valid,
    output frame_t frm
);
    logic             sclk_r, sclk_p, cs_r, cs_p, sdi_r;
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0] bit_cnt;

    wire sclk_fall = sclk_p && !sclk_r;
    wire cs_rise   = !cs_p && cs_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_r    <= 1'b0;
            sclk_p    <= 1'b0;
            cs_r      <= 1'b1;
            cs_p      <= 1'b1;
            sdi_r     <= 1'b0;
            shreg     <= '0;
            bit_cnt   <= '0;
            frm_valid <= 1'b0;
            frm       <= '0;
        end else begin
            sclk_r    <= sclk;
            sclk_p    <= sclk_r;
            cs_r      <= csn;
            cs_p      <= cs_r;
            sdi_r     <= sdi;
            frm_valid <= 1'b0;
            if (cs_p) begin
                bit_cnt <= '0;
            end else if (!cs_r && sclk_fall) begin
                shreg <= {shreg[FRAME_BITS-2:0], sdi_r};
                if (bit_cnt != CNT_W'(FRAME_BITS + 1))
                    bit_cnt <= bit_cnt + 1'b1;
            end
            if (cs_rise && bit_cnt == CNT_W'(FRAME_BITS)) begin
                frm_valid <= 1'b1;
                frm       <= frame_t'(shreg);
            end
        end
    end
endmodule

// File: rtl/mdac_decode.sv
module mdac_decode import mdac_pkg::*; #(
    parameter int unsigned NCH = 8,
    parameter int unsigned RES = 12
) (
    input  logic           frm_valid,
    input  frame_t         frm,
    output logic [RES-1:0] code,
    output logic [NCH-1:0] in_we,
    output logic [NCH-1:0] load_code,
    output logic [NCH-1:0] load_in,
    output logic [NCH-1:0] pd_we,
    output logic [1:0]     pd_val,
    output logic           mask_we,
    output logic [NCH-1:0] mask_val,
    output logic           tgt_we,
    output logic [1:0]     tgt_val,
    output logic           cfg_we,
    output logic [1:0]     cfg_val,
    output logic           soft_rst
);
    logic [NCH-1:0] hit;
    logic is_wr, is_ld, is_wla, is_wl, is_pd;
    wire  unused_frm = ^frm;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_hit
            localparam int unsigned AD = chan_addr(i, NCH);
            assign hit[i]      = (frm.addr == ADDR_ALL) || (frm.addr == 4'(AD));
            assign mask_val[i] = frm.data[AD];
            assign pd_we[i]    = is_pd && frm.data[AD];
        end
    endgenerate

    always_comb begin
        is_wr  = frm_valid && (frm.op == OP_WR_IN);
        is_ld  = frm_valid && (frm.op == OP_LOAD);
        is_wla = frm_valid && (frm.op == OP_WR_LOAD_ALL);
        is_wl  = frm_valid && (frm.op == OP_WR_LOAD);
        is_pd  = frm_valid && (frm.op == OP_PWR);

        code      = frm.data[19 -: RES];
        in_we     = {NCH{is_wr || is_wla || is_wl}} & hit;
        load_code = {NCH{is_wla || is_wl}} & hit;
        load_in   = ({NCH{is_ld}} & hit) | ({NCH{is_wla}} & ~hit);
        pd_val    = frm.data[9:8];
        mask_we   = frm_valid && (frm.op == OP_STB_MASK);
        tgt_we    = frm_valid && (frm.op == OP_CLR_SEL);
        tgt_val   = frm.data[1:0];
        cfg_we    = frm_valid && (frm.op == OP_CONFIG);
        cfg_val   = frm.data[1:0];
        soft_rst  = frm_valid && (frm.op == OP_SOFT_RST);
    end
endmodule

// File: rtl/mdac_chan.sv
module mdac_chan #(
    parameter int unsigned RES = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [RES-1:0] code,
    input  logic           in_we,
    input  logic           load_code,
    input  logic           load_in,
    input  logic           ldac,
    input  logic           clr_force,
    input  logic [RES-1:0] clr_code,
    input  logic           pd_we,
    input  logic [1:0]     pd_val,
    input  logic           mask_we,
    input  logic           mask_val,
    output logic [RES-1:0] dac_q,
    output logic [1:0]     pd_q
);
    localparam logic [RES-1:0] MID = {1'b1, {(RES-1){1'b0}}};

    logic [RES-1:0] in_q;
    logic           mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q   <= MID;
            dac_q  <= MID;
            pd_q   <= 2'd0;
            mask_q <= 1'b0;
        end else begin
            if (in_we)
                in_q <= code;
            if (clr_force)
                dac_q <= clr_code;
            else if (load_code)
                dac_q <= code;
            else if (load_in || (ldac && !mask_q))
                dac_q <= in_q;
            if (pd_we)
                pd_q <= pd_val;
            if (mask_we)
                mask_q <= mask_val;
        end
    end
endmodule

// File: rtl/mdac_cmd_core.sv
module mdac_cmd_core import mdac_pkg::*; #(
    parameter int unsigned NCH = 8,
    parameter int unsigned RES = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk,
    input  logic               csn,
    input  logic               sdi,
    input  logic               ldac,
    input  logic               clr,
    output logic [NCH*RES-1:0] dac_code,
    output logic [2*NCH-1:0]   pd_mode,
    output logic               int_ref_en,
    output logic               daisy_en
);
    localparam logic [RES-1:0] CODE_MID = {1'b1, {(RES-1){1'b0}}};

    logic           frm_valid;
    frame_t         frm;
    logic [RES-1:0] code;
    logic [NCH-1:0] in_we, load_code, load_in, pd_we, mask_val;
    logic [1:0]     pd_val, tgt_val, cfg_val;
    logic           mask_we, tgt_we, cfg_we, soft_rst;
    logic [1:0]     clr_tgt_q;
    logic [1:0]     cfg_q;
    logic [RES-1:0] clr_code;
    logic           clr_force;
    logic           state_rst;

    mdac_spi_rx u_rx (
        .clk(clk), .rst(rst), .sclk(sclk), .csn(csn), .sdi(sdi),
        .frm_valid(frm_valid), .frm(frm)
    );

    mdac_decode #(.NCH(NCH), .RES(RES)) u_dec (
        .frm_valid(frm_valid), .frm(frm), .code(code),
        .in_we(in_we), .load_code(load_code), .load_in(load_in),
        .pd_we(pd_we), .pd_val(pd_val), .mask_we(mask_we), .mask_val(mask_val),
        .tgt_we(tgt_we), .tgt_val(tgt_val), .cfg_we(cfg_we), .cfg_val(cfg_val),
        .soft_rst(soft_rst)
    );

    assign state_rst = rst || soft_rst;
    assign clr_force = clr && (clr_tgt_q != TGT_NONE);

    always_comb begin
        case (clr_tgt_q)
            TGT_ZERO: clr_code = '0;
            TGT_MID:  clr_code = CODE_MID;
            default:  clr_code = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            clr_tgt_q <= TGT_NONE;
        else if (tgt_we)
            clr_tgt_q <= tgt_val;
    end

    always_ff @(posedge clk) begin
        if (state_rst)
            cfg_q <= 2'b00;
        else if (cfg_we)
            cfg_q <= cfg_val;
    end

    assign int_ref_en = cfg_q[0];
    assign daisy_en   = cfg_q[1];

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            mdac_chan #(.RES(RES)) u_ch (
                .clk(clk), .rst(state_rst), .code(code),
                .in_we(in_we[i]), .load_code(load_code[i]), .load_in(load_in[i]),
                .ldac(ldac), .clr_force(clr_force), .clr_code(clr_code),
                .pd_we(pd_we[i]), .pd_val(pd_val),
                .mask_we(mask_we), .mask_val(mask_val[i]),
                .dac_q(dac_code[i*RES +: RES]), .pd_q(pd_mode[2*i +: 2])
            );
        end
    endgenerate
endmodule

// File: rtl/mdac_cmd_core_chk.sv
module mdac_cmd_core_chk import mdac_pkg::*; #(
    parameter int unsigned NCH = 8,
    parameter int unsigned RES = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               ldac,
    input logic               clr,
    input logic               frm_valid,
    input logic [1:0]         clr_tgt,
    input logic [NCH*RES-1:0] dac_code,
    input logic [2*NCH-1:0]   pd_mode,
    input logic               int_ref_en,
    input logic               daisy_en
);
    localparam logic [RES-1:0]     MID     = {1'b1, {(RES-1){1'b0}}};
    localparam logic [NCH*RES-1:0] MID_ALL = {NCH{MID}};

    function automatic logic [NCH*RES-1:0] fill(input logic [1:0] t);
        logic [RES-1:0] v;
        v = (t == TGT_ZERO) ? '0 : (t == TGT_MID) ? MID : '1;
        return {NCH{v}};
    endfunction

    p_reset_mid_r12: assert property (@(posedge clk) rst |=> (dac_code == MID_ALL));

    p_dac_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!frm_valid && !ldac && !clr) |=> $stable(dac_code));

    p_pd_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> $stable(pd_mode));

    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> $stable({int_ref_en, daisy_en}));

    p_clr_force_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && clr_tgt != TGT_NONE && !frm_valid) |=> (dac_code == fill(clr_tgt)));
endmodule

bind mdac_cmd_core mdac_cmd_core_chk #(.NCH(NCH), .RES(RES)) u_chk (
    .clk(clk), .rst(rst), .ldac(ldac), .clr(clr), .frm_valid(frm_valid),
    .clr_tgt(clr_tgt_q), .dac_code(dac_code), .pd_mode(pd_mode),
    .int_ref_en(int_ref_en), .daisy_en(daisy_en)
);

// File: tb/tb_mdac_cmd_core.sv
module tb_mdac_cmd_core;
    localparam int NA = 8;
    localparam int RA = 12;
    localparam int NB = 2;
    localparam int RB = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, sdi = 1'b0, csn_a = 1'b1, csn_b = 1'b1;
    logic ldac = 1'b0, clr = 1'b0;
    logic [NA*RA-1:0] dac_a;
    logic [2*NA-1:0]  pd_a;
    logic             ir_a, dc_a;
    logic [NB*RB-1:0] dac_b;
    logic [2*NB-1:0]  pd_b;
    logic             ir_b, dc_b;

    int n_chk = 0;
    int n_err = 0;

    logic [RA-1:0] m_in  [NA];
    logic [RA-1:0] m_dac [NA];
    logic [1:0]    m_pd  [NA];
    logic [NA-1:0] m_mask;
    logic [1:0]    m_tgt;
    logic [1:0]    m_cfg;

    always #2 clk = ~clk;

    mdac_cmd_core #(.NCH(NA), .RES(RA)) dut (
        .clk(clk), .rst(rst), .sclk(sclk), .csn(csn_a), .sdi(sdi), .ldac(ldac), .clr(clr),
        .dac_code(dac_a), .pd_mode(pd_a), .int_ref_en(ir_a), .daisy_en(dc_a)
    );

    mdac_cmd_core #(.NCH(NB), .RES(RB)) dut2 (
        .clk(clk), .rst(rst), .sclk(sclk), .csn(csn_b), .sdi(sdi), .ldac(ldac), .clr(clr),
        .dac_code(dac_b), .pd_mode(pd_b), .int_ref_en(ir_b), .daisy_en(dc_b)
    );

    function automatic void m_reset(input bit keep_tgt);
        for (int i = 0; i < NA; i++) begin
            m_in[i] = 12'h800; m_dac[i] = 12'h800; m_pd[i] = 2'd0;
        end
        m_mask = '0; m_cfg = 2'b00;
        if (!keep_tgt) m_tgt = 2'd3;
    endfunction

    function automatic void m_frame(input logic [3:0] op, input logic [3:0] ad, input logic [19:0] d);
        logic [RA-1:0] c;
        c = d[19:8];
        for (int i = 0; i < NA; i++) begin
            bit hit;
            hit = (ad == 4'hF) || (ad == 4'(i));
            case (op)
                4'd0: if (hit) m_in[i] = c;
                4'd1: if (hit) m_dac[i] = m_in[i];
                4'd2: begin if (hit) m_in[i] = c; m_dac[i] = m_in[i]; end
                4'd3: if (hit) begin m_in[i] = c; m_dac[i] = c; end
                4'd4: if (d[i]) m_pd[i] = d[9:8];
                4'd6: m_mask[i] = d[i];
                default: ;
            endcase
        end
        if (op == 4'd5) m_tgt = d[1:0];
        if (op == 4'd7) m_reset(1'b1);
        if (op == 4'd8) m_cfg = d[1:0];
    endfunction

    task automatic send_bits(input logic [63:0] bits, input int n, input bit to_b);
        @(negedge clk);
        if (to_b) csn_b = 1'b0; else csn_a = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = n - 1; k >= 0; k--) begin
            sdi = bits[k]; sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        csn_a = 1'b1; csn_b = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic frame_a(input logic [3:0] op, input logic [3:0] ad, input logic [19:0] d);
        send_bits({32'h0, 4'h0, op, ad, d}, 32, 1'b0);
        m_frame(op, ad, d);
    endtask

    task automatic pulse_ldac();
        @(negedge clk); ldac = 1'b1;
        @(negedge clk); ldac = 1'b0;
        for (int i = 0; i < NA; i++) if (!m_mask[i]) m_dac[i] = m_in[i];
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_clr();
        logic [RA-1:0] v;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        v = (m_tgt == 2'd0) ? 12'h000 : (m_tgt == 2'd1) ? 12'h800 : 12'hFFF;
        if (m_tgt != 2'd3) for (int i = 0; i < NA; i++) m_dac[i] = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_a(input string tag);
        logic [NA*RA-1:0] ed;
        logic [2*NA-1:0]  ep;
        for (int i = 0; i < NA; i++) begin
            ed[i*RA +: RA] = m_dac[i];
            ep[2*i +: 2]   = m_pd[i];
        end
        n_chk++;
        if (dac_a !== ed || pd_a !== ep || {dc_a, ir_a} !== m_cfg) begin
            n_err++;
            $display("FAIL %s: dac=%h pd=%h cfg=%b expected dac=%h pd=%h cfg=%b",
                     tag, dac_a, pd_a, {dc_a, ir_a}, ed, ep, m_cfg);
        end
    endtask

    task automatic check_b(input string tag, input logic [NB*RB-1:0] ed);
        n_chk++;
        if (dac_b !== ed) begin
            n_err++;
            $display("FAIL %s: dac=%h expected dac=%h", tag, dac_b, ed);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        logic [3:0] ops [7];
        ops = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8};
        void'($urandom(32'd20417));
        m_reset(1'b0);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        check_a("R12 reset state");
        check_b("R12 reset state two-channel", {16'h8000, 16'h8000});

        // R3: low payload bits are junk and must be ignored; R4 staging only
        frame_a(4'd0, 4'd2, {12'hABC, 8'hFF});
        check_a("R4 staging write leaves active code");
        frame_a(4'd1, 4'd2, 20'h0);
        check_a("R4 R3 load from staging, left-aligned");

        frame_a(4'd3, 4'd5, {12'h123, 8'h00});
        check_a("R5 write and load one channel");
        frame_a(4'd0, 4'd6, {12'h456, 8'h00});
        frame_a(4'd2, 4'd0, {12'h789, 8'h00});
        check_a("R5 write and load all");

        frame_a(4'd3, 4'hF, {12'h3C3, 8'h00});
        check_a("R6 broadcast address");
        frame_a(4'd3, 4'h9, {12'h111, 8'h00});
        check_a("R6 unmapped address");

        send_bits({32'h0, 32'h035AA000}, 31, 1'b0);
        check_a("R2 short frame discarded");
        send_bits({31'h0, 1'b1, 32'h035AA000}, 33, 1'b0);
        check_a("R2 long frame discarded");
        frame_a(4'd3, 4'd1, {12'h5AA, 8'h00});
        check_a("R1 exact frame accepted");

        frame_a(4'd4, 4'd0, {10'h0, 2'd3, 8'b1010_0001});
        check_a("R7 power-down mask and mode");
        frame_a(4'd4, 4'd0, {10'h0, 2'd2, 8'b0000_0100});
        check_a("R7 second mode other channel");

        frame_a(4'd6, 4'd0, 20'h0000F);
        frame_a(4'd0, 4'hF, {12'hE01, 8'h00});
        check_a("R8 staging written, active held");
        pulse_ldac();
        check_a("R8 strobe loads unmasked only");
        frame_a(4'd6, 4'd0, 20'h0);
        pulse_ldac();
        check_a("R8 strobe after mask cleared");

        frame_a(4'd0, 4'd3, {12'h0F0, 8'h00});
        frame_a(4'd5, 4'd0, 20'h00002);
        pulse_clr();
        check_a("R9 clear to full scale");
        frame_a(4'd1, 4'hF, 20'h0);
        check_a("R9 staging kept through clear");
        frame_a(4'd5, 4'd0, 20'h00003);
        pulse_clr();
        check_a("R9 disabled target ignores clr");
        frame_a(4'd5, 4'd0, 20'h00000);

        frame_a(4'd8, 4'd0, 20'h00003);
        check_a("R11 configuration flags");

        for (int u = 9; u < 16; u++) frame_a(4'(u), 4'hF, 20'hFFFFF);
        check_a("R13 unused opcodes");

        frame_a(4'd7, 4'd0, 20'h0);
        check_a("R10 command reset");
        pulse_clr();
        check_a("R10 clear target kept over command reset");

        send_bits({32'h0, 4'h0, 4'd3, 4'd3, 20'h12340}, 32, 1'b1);
        check_b("R6 two-channel address 3", {16'h1234, 16'h8000});
        send_bits({32'h0, 4'h0, 4'd3, 4'd1, 20'hFFFF0}, 32, 1'b1);
        check_b("R6 two-channel address 1 selects nothing", {16'h1234, 16'h8000});

        for (int it = 0; it < 180; it++) begin
            int  a;
            logic [3:0] ad;
            a  = $urandom_range(0, 9);
            ad = (a == 8) ? 4'hF : 4'(a);
            frame_a(ops[$urandom_range(0, 6)], ad, 20'($urandom));
            if (it % 5 == 4) pulse_ldac();
            check_a("R1 R5 R8 random mix");
        end

        report();
        $finish;
    end
endmodule